// File: doc/BRIEF.md
# Oversampled Serial Receiver with Parity Check

This block receives asynchronous serial characters on a single line. The line is sampled on a baud tick that runs at sixteen times the bit rate. The block finds the start bit and takes each following bit at its centre. It assembles 5 to 9 data bits, least significant bit first. It can then take one parity bit, and it ends with one stop bit. Parity is recomputed over the received data bits and compared with the received parity bit. A low stop bit is reported as a framing error.

Each finished character goes into a single-entry holding stage. The stage presents it on a valid/ready output: the low byte, the ninth data bit, and the parity and framing flags. All of these belong to the same character and are valid together. The handshake pops the entry. Read the ninth bit and the flags in the same cycle as the low byte or earlier, because after the pop they read zero. Back-pressure rules:
- While `rd_valid` is high and `rd_ready` is low, every field is held stable.
- A character that finishes while the entry is still occupied, with no pop in that cycle, is discarded.
- A pop and a new store in the same cycle are allowed, and the new character takes the entry.

The character size and parity mode codes are the ones the matching transmitter uses. The caller keeps `cfg_size` and `cfg_parity` steady while a character is in flight. The receiver also latches both at the start bit.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rd_valid` is low and `rd_data`, `rd_bit8`, `rd_parity_err` and `rd_frame_err` are all zero.
- R2: A reception begins on a falling edge of the synchronised line and is confirmed only if the line is still low on the 8th baud tick after that edge. A low pulse shorter than that produces no character.
- R3: `cfg_size` selects the data bit count as follows: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. The codes 100, 101 and 110 act as 8. Data arrives least significant bit first, and the unused upper bits of `rd_data` read zero.
- R4: With 9 data bits, the ninth received data bit appears on `rd_bit8`. With any other size, `rd_bit8` is zero.
- R5: The `cfg_parity` codes are: 10 for even, 11 for odd. In these modes one parity bit follows the data. `rd_parity_err` is set when that bit differs from the XOR of the data bits (even) or from its inverse (odd).
- R6: With `cfg_parity` at 00 (off) or 01 (reserved), no parity bit is expected and `rd_parity_err` stays zero.
- R7: A stop bit sampled low sets `rd_frame_err`, and the character is still stored and presented.
- R8: `rd_valid` rises on the clock after the baud tick that samples the stop bit. It stays high, with all fields stable, until a cycle with `rd_ready` high.
- R9: A cycle with `rd_valid` and `rd_ready` both high pops the entry. On the next cycle `rd_valid` is low and all fields, including `rd_bit8`, read zero, unless a new character is stored in that same cycle.
- R10: A character that completes while the entry is occupied and not being popped is dropped. The held character is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_size | input | 3 | Character size code |
| cfg_parity | input | 2 | Parity mode code |
| rd_valid | output | 1 | A received character is held |
| rd_ready | input | 1 | Pops the held character when `rd_valid` is high |
| rd_data | output | 8 | Low data byte |
| rd_bit8 | output | 1 | Ninth data bit |
| rd_parity_err | output | 1 | Parity mismatch for the held character |
| rd_frame_err | output | 1 | Stop bit was low for the held character |

## Verification
Each bit that the bench drives lasts exactly 16 baud ticks. The line passes two synchroniser flops before it is sampled at a centre tick. So the held character appears on the clock after the stop bit's centre tick, well before the bench finishes driving that stop bit. The bench checks the fields once the whole stop bit has been driven, at a falling clock edge. Pops are driven for one cycle, and the emptied state is checked on the falling edge after the next rising edge. The rejected-glitch and drop cases are checked two full bit times after the stimulus, when any wrongly accepted character would already have appeared.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [8:0] bits;
    logic       perr;
    logic       ferr;
  } rx_char_t;

  localparam logic [1:0] PAR_OFF  = 2'b00;
  localparam logic [1:0] PAR_RSV  = 2'b01;
  localparam logic [1:0] PAR_EVEN = 2'b10;
  localparam logic [1:0] PAR_ODD  = 2'b11;

  function automatic logic [3:0] size_to_bits(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic parity_on(input logic [1:0] mode);
    return mode[1];
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic line_fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], line_in};
  end

  assign line_s    = chain[STAGES-1];
  assign line_fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_s,
  input  logic       line_fall,
  input  logic [2:0] cfg_size,
  input  logic [1:0] cfg_parity,
  output logic       done,
  output rx_char_t   char_out
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [8:0]    sh;
  logic          par_bit;
  logic [3:0]    nbits_q;
  logic [1:0]    mode_q;
  logic          at_centre;

  assign at_centre = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      par_bit <= 1'b0;
      nbits_q <= 4'd8;
      mode_q  <= PAR_OFF;
    end else begin
      case (state)
        ST_IDLE: if (line_fall) begin
          state   <= ST_START;
          cnt     <= '0;
          idx     <= '0;
          sh      <= '0;
          par_bit <= 1'b0;
          nbits_q <= size_to_bits(cfg_size);
          mode_q  <= cfg_parity;
        end
        ST_START: if (tick) begin
          if (cnt == MID) begin
            cnt   <= '0;
            state <= line_s ? ST_IDLE : ST_DATA;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: if (tick) begin
          if (cnt == LAST) begin
            cnt <= '0;
            sh  <= sh | (9'(line_s) << idx);
            if (idx == nbits_q - 4'd1)
              state <= parity_on(mode_q) ? ST_PAR : ST_STOP;
            else
              idx <= idx + 4'd1;
          end else cnt <= cnt + 1'b1;
        end
        ST_PAR: if (tick) begin
          if (cnt == LAST) begin
            cnt     <= '0;
            par_bit <= line_s;
            state   <= ST_STOP;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP: if (tick) begin
          if (cnt == LAST) state <= ST_IDLE;
          else             cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done          = (state == ST_STOP) && at_centre;
  assign char_out.bits = sh;
  assign char_out.ferr = ~line_s;
  assign char_out.perr = parity_on(mode_q) && (par_bit != ((^sh) ^ mode_q[0]));
endmodule

// File: rtl/srx_holding.sv
module srx_holding
  import srx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     store,
  input  rx_char_t char_in,
  input  logic     pop_ready,
  output logic     valid,
  output rx_char_t held
);
  logic popping;
  assign popping = valid && pop_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      held  <= '0;
    end else if (store && (!valid || popping)) begin
      valid <= 1'b1;
      held  <= char_in;
    end else if (popping) begin
      valid <= 1'b0;
      held  <= '0;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic [2:0] cfg_size,
  input  logic [1:0] cfg_parity,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       rd_bit8,
  output logic       rd_parity_err,
  output logic       rd_frame_err
);
  logic     line_s, line_fall, frame_done;
  rx_char_t new_char, held_char;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(rxd),
    .line_s(line_s), .line_fall(line_fall)
  );

  srx_deframer #(.OVERSAMPLE(OVERSAMPLE)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick),
    .line_s(line_s), .line_fall(line_fall),
    .cfg_size(cfg_size), .cfg_parity(cfg_parity),
    .done(frame_done), .char_out(new_char)
  );

  srx_holding u_hold (
    .clk(clk), .rst_n(rst_n), .store(frame_done), .char_in(new_char),
    .pop_ready(rd_ready), .valid(rd_valid), .held(held_char)
  );

  assign rd_data       = held_char.bits[7:0];
  assign rd_bit8       = held_char.bits[8];
  assign rd_parity_err = held_char.perr;
  assign rd_frame_err  = held_char.ferr;
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cfg_size,
  input logic [1:0] cfg_parity,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       rd_bit8,
  input logic       rd_parity_err,
  input logic       rd_frame_err,
  input logic       frame_done
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_bit8)
      && $stable(rd_parity_err) && $stable(rd_frame_err));

  // R9
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == 8'h00) && !rd_bit8 && !rd_parity_err && !rd_frame_err);

  // R8
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(frame_done));

  // R4
  bit8_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && (cfg_size != 3'b111) && $stable(cfg_size) |-> !rd_bit8);

  // R6
  no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !cfg_parity[1] && $stable(cfg_parity) |-> !rd_parity_err);
endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_parity(cfg_parity),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_bit8(rd_bit8), .rd_parity_err(rd_parity_err),
  .rd_frame_err(rd_frame_err), .frame_done(frame_done)
);

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick;
  logic       rxd = 1'b1;
  logic [2:0] cfg_size = 3'b011;
  logic [1:0] cfg_parity = 2'b00;
  logic       rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit8, rd_parity_err, rd_frame_err;

  int checks = 0;
  int errors = 0;
  logic [1:0] div = 2'd0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) div <= (div == 2'd2) ? 2'd0 : div + 2'd1;
  assign baud_tick = (div == 2'd0);

  serial_rx_core uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_size(cfg_size), .cfg_parity(cfg_parity),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_bit8(rd_bit8), .rd_parity_err(rd_parity_err), .rd_frame_err(rd_frame_err)
  );

  function automatic int nbits_of(input logic [2:0] code);
    if (code == 3'b000) return 5;
    if (code == 3'b001) return 6;
    if (code == 3'b010) return 7;
    if (code == 3'b111) return 9;
    return 8;
  endfunction

  function automatic logic [8:0] mask_of(input int n);
    return 9'((1 << n) - 1);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!baud_tick) @(negedge clk);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    wait_ticks(16);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic [1:0] pm,
                      input logic flip_par, input logic stop_v);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (pm[1]) drive_bit((^(d & mask_of(nb))) ^ pm[0] ^ flip_par);
    drive_bit(stop_v);
    rxd = 1'b1;
  endtask

  task automatic expect_char(input string req, input logic [8:0] d, input int nb,
                             input logic [1:0] pm, input logic flip_par, input logic stop_v);
    logic [8:0] m;
    m = d & mask_of(nb);
    check({req, " valid"}, int'(rd_valid), 1);
    check({req, " R3 data"}, int'(rd_data), int'(m[7:0]));
    check({req, " R4 bit8"}, int'(rd_bit8), int'(m[8]));
    check({req, " R5/R6 perr"}, int'(rd_parity_err), int'(pm[1] & flip_par));
    check({req, " R7 ferr"}, int'(rd_frame_err), int'(!stop_v));
  endtask

  task automatic pop_and_check(input string req);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    check({req, " R9 valid after pop"}, int'(rd_valid), 0);
    check({req, " R9 bit8 after pop"}, int'(rd_bit8), 0);
    check({req, " R9 data after pop"}, int'(rd_data), 0);
  endtask

  task automatic run_one(input string req, input logic [2:0] sz, input logic [1:0] pm,
                         input logic [8:0] d, input logic flip, input logic stop_v);
    cfg_size = sz;
    cfg_parity = pm;
    drive_bit(1'b1);
    send(d, nbits_of(sz), pm, flip, stop_v);
    drive_bit(1'b1);
    expect_char(req, d, nbits_of(sz), pm, flip, stop_v);
    pop_and_check(req);
  endtask

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(rd_valid), 0);
    check("R1 data", int'(rd_data), 0);
    check("R1 flags", int'({rd_bit8, rd_parity_err, rd_frame_err}), 0);

    // R2: glitch shorter than half a bit is rejected
    rxd = 1'b0;
    wait_ticks(4);
    rxd = 1'b1;
    wait_ticks(32);
    check("R2 glitch rejected", int'(rd_valid), 0);

    // Directed corners
    run_one("R3 five-bit", 3'b000, 2'b00, 9'h1F5, 1'b0, 1'b1);
    run_one("R3 code100 as eight", 3'b100, 2'b00, 9'h1A5, 1'b0, 1'b1);
    run_one("R4 nine-bit even ok", 3'b111, 2'b10, 9'h1C3, 1'b0, 1'b1);
    run_one("R5 nine-bit odd bad", 3'b111, 2'b11, 9'h155, 1'b1, 1'b1);
    run_one("R6 reserved mode", 3'b011, 2'b01, 9'h03C, 1'b0, 1'b1);
    run_one("R7 framing", 3'b011, 2'b10, 9'h0F0, 1'b0, 1'b0);

    // R10: second character dropped while entry is held
    cfg_size = 3'b011;
    cfg_parity = 2'b00;
    drive_bit(1'b1);
    send(9'h011, 8, 2'b00, 1'b0, 1'b1);
    drive_bit(1'b1);
    send(9'h0EE, 8, 2'b00, 1'b0, 1'b1);
    drive_bit(1'b1);
    drive_bit(1'b1);
    check("R10 held kept", int'(rd_data), 32'h11);
    check("R8 still valid", int'(rd_valid), 1);
    pop_and_check("R10");

    // Constrained random frames
    for (int k = 0; k < 30; k++) begin
      logic [2:0] sz;
      logic [1:0] pm;
      logic [8:0] d;
      logic flip, stp;
      sz   = 3'($urandom_range(0, 7));
      pm   = 2'($urandom_range(0, 3));
      d    = 9'($urandom_range(0, 511));
      flip = ($urandom_range(0, 3) == 0);
      stp  = ($urandom_range(0, 7) != 0);
      run_one("R3/R5 random", sz, pm, d, flip, stp);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule